// File: doc/BRIEF.md
# I/O Bus Width Packing Unit

This unit sits between a 32-bit internal word port and a 16-bit external I/O data bus. One internal command carries a direction, a beat width and a byte order. A write command splits the supplied 32-bit word into a series of narrow bus beats. A read command assembles a series of narrow bus beats into one 32-bit word, which it then presents on the internal read port.

Beats are 8 bits wide for DMA traffic on byte channels and 16 bits wide for processor traffic on halfword channels. The selected byte order decides which part of the word travels first. The block drives one beat strobe for each beat and holds it until the external side acknowledges. With the strobe it drives a byte-enable that shows which lanes of the 16-bit bus carry data. An abort input drops the word in progress at any point.

Top module: `io_pack_unit`

## Requirements
- R1: `cmd_ready_o` is high only while the unit is idle. A command is accepted in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high and `abort_i` is low. The first beat strobe appears in the next cycle.
- R2: A narrow command (`cmd_wide_i`=0) runs four beats. Each beat uses the low lane only: `bus_be_o`=2'b01, and on writes `bus_wdata_o[15:8]` is zero.
- R3: A wide command (`cmd_wide_i`=1) runs two beats. Each beat uses both lanes: `bus_be_o`=2'b11.
- R4: With little-endian order (`cmd_big_i`=0), beat k carries word bits [8k+7:8k] when narrow and [16k+15:16k] when wide.
- R5: With big-endian order (`cmd_big_i`=1), the first beat carries bits [31:24] when narrow and [31:16] when wide. The following beats step down through the word.
- R6: A narrow read places `bus_rdata_i[7:0]` of each acknowledged beat into the byte slot that R4/R5 give. `bus_rdata_i[15:8]` has no effect on the result.
- R7: A wide read places `bus_rdata_i[15:0]` of each acknowledged beat into the halfword slot that R4/R5 give.
- R8: `rd_valid_o` rises only in the cycle after the last beat of a read is acknowledged. It then stays high with stable `rd_data_o` until `rd_ready_i` is seen. No new command is accepted before then.
- R9: `bus_strobe` (`bus_stb_o`) stays high, with the same beat position, until `bus_ack_i` is sampled high. `bus_ack_i` has no effect while the strobe is low.
- R10: `abort_i` takes priority over every other input. In the next cycle the unit is idle with `rd_valid_o` low, the partial word is discarded, and the next command starts at its first beat.
- R11: While reset is held, `bus_stb_o` and `rd_valid_o` are low and `cmd_ready_o` is high.
- R12: Direction, width, byte order and write data are captured when a command is accepted. Changes on those inputs during a command have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Discard the word in progress and return to idle |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Unit idle, command can be taken |
| cmd_write_i | input | 1 | 1 = word to bus (unpack), 0 = bus to word (pack) |
| cmd_wide_i | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| cmd_big_i | input | 1 | 1 = big-endian beat order |
| cmd_wdata_i | input | 32 | Word to unpack |
| rd_valid_o | output | 1 | Assembled word available |
| rd_ready_i | input | 1 | Internal side takes the assembled word |
| rd_data_o | output | 32 | Assembled word |
| bus_stb_o | output | 1 | Beat strobe, held until acknowledged |
| bus_ack_i | input | 1 | Beat completion |
| bus_be_o | output | 2 | Active lanes of the current beat |
| bus_wdata_o | output | 16 | Write beat data |
| bus_rdata_i | input | 16 | Read beat data, sampled with the acknowledge |

## Verification
The assertions assume that the bus side moves a beat only through `bus_ack_i` and that the internal side uses `rd_ready_i` to release the word. They do not assume the acknowledge waits for the strobe. The stimulus therefore drives `bus_ack_i`, `rd_ready_i` and `cmd_valid_i` at random whether or not the unit is waiting for them. It changes the command fields freely while a word is in flight, and it fills the unused upper read lane with random data. Aborts are held back for the first half of the run. After that they arrive rarely and at arbitrary points: mid-beat, while the word is held, or together with a command.

// File: rtl/io_pack_pkg.sv
package io_pack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_HOLD = 2'd2
  } pk_state_e;

endpackage

// File: rtl/io_pack_ctrl.sv
module io_pack_ctrl
  import io_pack_pkg::*;
#(
  parameter int NARROW_BEATS = 4,
  parameter int WIDE_BEATS   = 2,
  parameter int CNT_W        = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  input  logic             cmd_wide_i,
  input  logic             cmd_big_i,
  input  logic             bus_ack_i,
  input  logic             rd_ready_i,
  output logic             cmd_ready_o,
  output logic             cmd_fire_o,
  output logic             bus_stb_o,
  output logic             beat_done_o,
  output logic             rd_valid_o,
  output logic             cur_write_o,
  output logic             cur_wide_o,
  output logic             cur_big_o,
  output logic [CNT_W-1:0] beat_idx_o
);

  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_BEATS - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_BEATS - 1);

  pk_state_e        state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             write_q, write_d;
  logic             wide_q, wide_d;
  logic             big_q, big_d;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    write_d  = write_q;
    wide_d   = wide_q;
    big_d    = big_q;
    last_idx = wide_q ? WIDE_LAST : NARROW_LAST;

    cmd_ready_o = (state_q == ST_IDLE);
    bus_stb_o   = (state_q == ST_BEAT);
    rd_valid_o  = (state_q == ST_HOLD);
    cmd_fire_o  = cmd_ready_o && cmd_valid_i && !abort_i;
    beat_done_o = bus_stb_o && bus_ack_i && !abort_i;

    if (abort_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_fire_o) begin
            state_d = ST_BEAT;
            idx_d   = '0;
            write_d = cmd_write_i;
            wide_d  = cmd_wide_i;
            big_d   = cmd_big_i;
          end
        end
        ST_BEAT: begin
          if (beat_done_o) begin
            if (idx_q == last_idx) begin
              idx_d   = '0;
              state_d = write_q ? ST_IDLE : ST_HOLD;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (rd_ready_i) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      big_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      write_q <= write_d;
      wide_q  <= wide_d;
      big_q   <= big_d;
    end
  end

  assign cur_write_o = write_q;
  assign cur_wide_o  = wide_q;
  assign cur_big_o   = big_q;
  assign beat_idx_o  = idx_q;

  // R1: an accepted command opens a beat on the next cycle
  p_fire_opens_beat_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_fire_o |=> bus_stb_o);

  // R9: an unacknowledged beat keeps its strobe and position
  p_stb_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_stb_o && !bus_ack_i && !abort_i) |=> (bus_stb_o && $stable(beat_idx_o)));

  // R8: assembled word held until taken
  p_hold_word_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !abort_i) |=> rd_valid_o);

  // R10: abort leaves the unit idle
  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_i |=> (cmd_ready_o && !bus_stb_o && !rd_valid_o));

endmodule

// File: rtl/io_pack_slot.sv
module io_pack_slot #(
  parameter int NARROW_BEATS = 4,
  parameter int WIDE_BEATS   = 2,
  parameter int CNT_W        = 2
) (
  input  logic [CNT_W-1:0] beat_idx_i,
  input  logic             wide_i,
  input  logic             big_i,
  output logic [CNT_W-1:0] lane_base_o
);

  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_BEATS - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_BEATS - 1);

  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] word_pos;

  always_comb begin
    last_idx    = wide_i ? WIDE_LAST : NARROW_LAST;
    word_pos    = big_i ? (last_idx - beat_idx_i) : beat_idx_i;
    lane_base_o = wide_i ? CNT_W'(word_pos << 1) : word_pos;
  end

endmodule

// File: rtl/io_pack_unpack.sv
module io_pack_unpack #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              stb_i,
  input  logic              write_i,
  input  logic              wide_i,
  input  logic [CNT_W-1:0]  lane_base_i,
  output logic [BUS_W-1:0]  bus_wdata_o,
  output logic [1:0]        bus_be_o
);

  logic [WORD_W-1:0] word_q, word_d;
  logic [LANE_W-1:0] lanes [LANES];
  logic [CNT_W-1:0]  hi_idx;
  logic [LANE_W-1:0] lo_lane, hi_lane;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lanes[g] = word_q[g*LANE_W +: LANE_W];
  end

  always_comb begin
    hi_idx  = lane_base_i + 1'b1;
    lo_lane = lanes[lane_base_i];
    hi_lane = lanes[hi_idx];
    bus_wdata_o = '0;
    bus_be_o    = 2'b00;
    if (stb_i) begin
      bus_be_o = wide_i ? 2'b11 : 2'b01;
      if (write_i) begin
        bus_wdata_o = wide_i ? {hi_lane, lo_lane} : {{(BUS_W-LANE_W){1'b0}}, lo_lane};
      end
    end
  end

  // R2: a narrow write beat leaves the upper lane quiet
  p_upper_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stb_i && write_i && !wide_i) |-> (bus_wdata_o[BUS_W-1:LANE_W] == '0));

endmodule

// File: rtl/io_pack_gather.sv
module io_pack_gather #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              abort_i,
  input  logic              capture_i,
  input  logic              wide_i,
  input  logic [CNT_W-1:0]  lane_base_i,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic [WORD_W-1:0] word_o
);

  logic [CNT_W-1:0] hi_idx;
  assign hi_idx = lane_base_i + 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q, lane_d;
    logic              we_lo, we_hi;

    always_comb begin
      we_lo  = capture_i && (lane_base_i == CNT_W'(g));
      we_hi  = capture_i && wide_i && (hi_idx == CNT_W'(g));
      lane_d = lane_q;
      if (clear_i || abort_i) lane_d = '0;
      else if (we_lo)         lane_d = bus_rdata_i[LANE_W-1:0];
      else if (we_hi)         lane_d = bus_rdata_i[BUS_W-1:LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign word_o[g*LANE_W +: LANE_W] = lane_q;
  end

  // R10: an abort empties the partial word
  p_abort_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_i |=> (word_o == '0));

endmodule

// File: rtl/io_pack_unit.sv
module io_pack_unit #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              abort_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic              cmd_wide_i,
  input  logic              cmd_big_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              bus_stb_o,
  input  logic              bus_ack_i,
  output logic [1:0]        bus_be_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  input  logic [BUS_W-1:0]  bus_rdata_i
);

  localparam int LANE_W       = BUS_W / 2;
  localparam int LANES        = WORD_W / LANE_W;
  localparam int NARROW_BEATS = LANES;
  localparam int WIDE_BEATS   = WORD_W / BUS_W;
  localparam int CNT_W        = $clog2(LANES);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             cmd_fire;
  logic             beat_done;
  logic             cur_write, cur_wide, cur_big;
  logic [CNT_W-1:0] beat_idx;
  logic [CNT_W-1:0] lane_base;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  io_pack_ctrl #(
    .NARROW_BEATS(NARROW_BEATS),
    .WIDE_BEATS  (WIDE_BEATS),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .abort_i     (abort_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_write_i (cmd_write_i),
    .cmd_wide_i  (cmd_wide_i),
    .cmd_big_i   (cmd_big_i),
    .bus_ack_i   (bus_ack_i),
    .rd_ready_i  (rd_ready_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_fire_o  (cmd_fire),
    .bus_stb_o   (bus_stb_o),
    .beat_done_o (beat_done),
    .rd_valid_o  (rd_valid_o),
    .cur_write_o (cur_write),
    .cur_wide_o  (cur_wide),
    .cur_big_o   (cur_big),
    .beat_idx_o  (beat_idx)
  );

  io_pack_slot #(
    .NARROW_BEATS(NARROW_BEATS),
    .WIDE_BEATS  (WIDE_BEATS),
    .CNT_W       (CNT_W)
  ) u_slot (
    .beat_idx_i  (beat_idx),
    .wide_i      (cur_wide),
    .big_i       (cur_big),
    .lane_base_o (lane_base)
  );

  io_pack_unpack #(
    .WORD_W(WORD_W),
    .BUS_W (BUS_W),
    .LANE_W(LANE_W),
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_unpack (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .load_i      (cmd_fire),
    .word_i      (cmd_wdata_i),
    .stb_i       (bus_stb_o),
    .write_i     (cur_write),
    .wide_i      (cur_wide),
    .lane_base_i (lane_base),
    .bus_wdata_o (bus_wdata_o),
    .bus_be_o    (bus_be_o)
  );

  io_pack_gather #(
    .WORD_W(WORD_W),
    .BUS_W (BUS_W),
    .LANE_W(LANE_W),
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_gather (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .clear_i     (cmd_fire),
    .abort_i     (abort_i),
    .capture_i   (beat_done && !cur_write),
    .wide_i      (cur_wide),
    .lane_base_i (lane_base),
    .bus_rdata_i (bus_rdata_i),
    .word_o      (rd_data_o)
  );

  // R8: the offered word does not move while it waits
  p_rd_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !abort_i) |=> $stable(rd_data_o));

  // R9: write data and lanes stay put while a beat waits
  p_beat_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_stb_o && !bus_ack_i && !abort_i) |=> ($stable(bus_wdata_o) && $stable(bus_be_o)));

endmodule

// File: tb/io_pack_unit_tb.sv
module io_pack_unit_tb;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        abort_i;
  logic        cmd_valid_i;
  logic        cmd_ready_o;
  logic        cmd_write_i;
  logic        cmd_wide_i;
  logic        cmd_big_i;
  logic [31:0] cmd_wdata_i;
  logic        rd_valid_o;
  logic        rd_ready_i;
  logic [31:0] rd_data_o;
  logic        bus_stb_o;
  logic        bus_ack_i;
  logic [1:0]  bus_be_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  io_pack_unit u_dut (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .abort_i     (abort_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_write_i (cmd_write_i),
    .cmd_wide_i  (cmd_wide_i),
    .cmd_big_i   (cmd_big_i),
    .cmd_wdata_i (cmd_wdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rd_data_o   (rd_data_o),
    .bus_stb_o   (bus_stb_o),
    .bus_ack_i   (bus_ack_i),
    .bus_be_o    (bus_be_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  bit          m_busy, m_write, m_wide, m_big, m_hold;
  int          m_k, m_left;
  logic [31:0] m_data, m_word;

  function automatic int slot_of(int k, bit wide, bit big);
    int n = wide ? 2 : 4;
    return big ? (n - 1 - k) : k;
  endfunction

  task automatic model_step();
    int          w;
    int          s;
    logic [31:0] mask;
    logic [31:0] beat;
    logic [15:0] exp_wd;
    string       tag;
    w    = m_wide ? 16 : 8;
    mask = m_wide ? 32'h0000_ffff : 32'h0000_00ff;

    chk(cmd_ready_o == !m_busy, "R1 cmd_ready", 32'(cmd_ready_o), 32'(!m_busy));
    chk(bus_stb_o == (m_left > 0), "R9 strobe", 32'(bus_stb_o), 32'(m_left > 0));
    chk(rd_valid_o == m_hold, "R8 rd_valid", 32'(rd_valid_o), 32'(m_hold));

    if (m_left > 0) begin
      s    = slot_of(m_k, m_wide, m_big);
      beat = (m_data >> (s * w)) & mask;
      if (m_wide) chk(bus_be_o == 2'b11, "R3 byte enable", 32'(bus_be_o), 32'h3);
      else        chk(bus_be_o == 2'b01, "R2 byte enable", 32'(bus_be_o), 32'h1);
      if (m_write) begin
        exp_wd = beat[15:0];
        tag    = m_big ? "R5 write beat" : "R4 write beat";
        if (!m_wide) tag = {tag, " R2"};
        if (cmd_valid_i) tag = {tag, " R12"};
        chk(bus_wdata_o == exp_wd, tag, 32'(bus_wdata_o), 32'(exp_wd));
      end
    end
    if (m_hold) begin
      tag = m_wide ? "R7 word" : "R6 word";
      if (cmd_valid_i) tag = {tag, " R12"};
      chk(rd_data_o == m_word, tag, rd_data_o, m_word);
    end

    // advance to the state after the coming edge
    if (abort_i) begin
      m_busy = 1'b0; m_hold = 1'b0; m_left = 0; m_k = 0; m_word = '0;
    end else if (!m_busy && cmd_valid_i) begin
      m_busy  = 1'b1;
      m_write = cmd_write_i;
      m_wide  = cmd_wide_i;
      m_big   = cmd_big_i;
      m_data  = cmd_wdata_i;
      m_word  = '0;
      m_k     = 0;
      m_left  = cmd_wide_i ? 2 : 4;
    end else if (m_left > 0 && bus_ack_i) begin
      if (!m_write) begin
        s      = slot_of(m_k, m_wide, m_big);
        m_word = m_word | ((32'(bus_rdata_i) & mask) << (s * w));
      end
      m_k++;
      m_left--;
      if (m_left == 0) begin
        if (m_write) m_busy = 1'b0;
        else         m_hold = 1'b1;
      end
    end else if (m_hold && rd_ready_i) begin
      m_hold = 1'b0;
      m_busy = 1'b0;
    end
  endtask

  always begin
    @(negedge clk_i);
    #9;
    if (chk_en && !done) model_step();
  end

  initial begin
    rst_n_i     = 1'b0;
    abort_i     = 1'b0;
    cmd_valid_i = 1'b0;
    cmd_write_i = 1'b0;
    cmd_wide_i  = 1'b0;
    cmd_big_i   = 1'b0;
    cmd_wdata_i = '0;
    rd_ready_i  = 1'b0;
    bus_ack_i   = 1'b0;
    bus_rdata_i = '0;
    m_busy = 1'b0; m_hold = 1'b0; m_write = 1'b0; m_wide = 1'b0; m_big = 1'b0;
    m_left = 0; m_k = 0; m_data = '0; m_word = '0;

    repeat (3) @(negedge clk_i);
    #9;
    chk(bus_stb_o == 1'b0, "R11 strobe in reset", 32'(bus_stb_o), 32'h0);
    chk(rd_valid_o == 1'b0, "R11 rd_valid in reset", 32'(rd_valid_o), 32'h0);
    chk(cmd_ready_o == 1'b1, "R11 ready in reset", 32'(cmd_ready_o), 32'h1);
    @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_en = 1'b1;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      cmd_valid_i = ($urandom_range(0, 2) != 0);
      cmd_write_i = $urandom_range(0, 1) != 0;
      cmd_wide_i  = $urandom_range(0, 1) != 0;
      cmd_big_i   = $urandom_range(0, 1) != 0;
      cmd_wdata_i = $urandom;
      bus_ack_i   = ($urandom_range(0, 2) != 0);
      bus_rdata_i = 16'($urandom);
      rd_ready_i  = ($urandom_range(0, 1) != 0);
      abort_i     = (cyc > 3000) && ($urandom_range(0, 40) == 0);
      @(negedge clk_i);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule